// File: doc/BRIEF.md
# IOM-2 Line-Card Channel Framer

This block connects to the four-wire IOM-2 bus in its line-card arrangement. It runs on the double-rate data clock (DCL), so every data bit spans two clock cycles. An 8 kHz frame pulse realigns it at the start of each frame. A frame has `NCH` channels of 32 bits each, eight by default, which gives 256 bits and 512 DCL cycles. Each channel serves one ISDN transceiver or one pair of codecs. Inside a channel the bits are ordered B1, B2, Monitor, then a control byte made of D (2 bits), C/I (4 bits), MR and MX.

In the downstream direction, the block shifts the received line into per-channel registers and splits each register into field outputs. In the upstream direction, it serialises one 32-bit transmit word per channel. It drives the shared upstream line only during the slots of channels whose enable bit is set, and it gives a one-cycle strobe each time the last channel of a frame has been captured. The same frame pulse times both directions. The monitor-channel handshake and any switching logic belong to the surrounding design.

Top module: `iomlc_framer`

## Requirements
- R1: While `rst_n` is low, and after it rises, all received fields are zero and `du_oe` and `frame_end` are low until a frame pulse arrives.
- R2: Until `fsc` is first sampled high, `du_oe` stays low whatever `tx_en` holds, no field output changes and `frame_end` never pulses.
- R3: When `fsc` is sampled high at a rising clock edge, the next cycle is the first DCL cycle of bit 0 of channel 0. Each bit lasts two cycles, and channel c occupies frame bits 32c to 32c+31.
- R4: `du` sends the channel word MSB first. Bit k of channel c's slot is bit 31-k of `tx_word[c*32 +: 32]`, where B1 sits in [31:24], B2 in [23:16], Monitor in [15:8], D in [7:6], C/I in [5:2], MR in [1] and MX in [0]. The word and its enable bit are taken at the rising edge that begins the slot.
- R5: `du_oe` is high for all 64 cycles of channel c's slot when `tx_en[c]` is 1, and low for the whole slot when it is 0. It changes only at slot boundaries.
- R6: `dd` is sampled at the rising edge that ends the second cycle of each bit. The 32 bits of channel c, with the first received as MSB, appear on channel c's field outputs after the edge that ends that slot. They hold until the same slot of a later frame ends.
- R7: The received word is split with the same layout as R4. Channel c's fields are found at `rx_b1[c*8 +: 8]`, `rx_b2[c*8 +: 8]`, `rx_mon[c*8 +: 8]`, `rx_d[c*2 +: 2]`, `rx_ci[c*4 +: 4]`, `rx_mr[c]` and `rx_mx[c]`.
- R8: `frame_end` is a single-cycle pulse in the cycle after the last bit of channel NCH-1 is sampled. It coincides with that channel's new fields.
- R9: A frame pulse in the middle of a frame restarts at channel 0, bit 0. A channel whose slot is cut short keeps its previous fields, and it is captured correctly on the next full slot.
- R10: Without further frame pulses, the block keeps running and wraps to channel 0 every NCH*64 cycles, capturing and strobing as before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate data clock (DCL) |
| rst_n | input | 1 | Synchronous active-low reset |
| fsc | input | 1 | Frame pulse, sampled on the rising edge |
| dd | input | 1 | Downstream serial data |
| tx_word | input | NCH*32 | Per-channel upstream words, channel c at [c*32 +: 32] |
| tx_en | input | NCH | Per-channel upstream drive enable |
| du | output | 1 | Upstream serial data, zero when not driving |
| du_oe | output | 1 | Upstream output enable for the pad |
| rx_b1 | output | NCH*8 | Received B1 per channel |
| rx_b2 | output | NCH*8 | Received B2 per channel |
| rx_mon | output | NCH*8 | Received Monitor byte per channel |
| rx_d | output | NCH*2 | Received D bits per channel |
| rx_ci | output | NCH*4 | Received C/I per channel |
| rx_mr | output | NCH | Received MR bit per channel |
| rx_mx | output | NCH | Received MX bit per channel |
| frame_end | output | 1 | One-cycle strobe after the last channel is captured |

## Verification
The bench builds the block with the default NCH = 8. This gives the full 512-cycle line-card frame, so every channel index, the wrap from channel 7 to channel 0, and slots with mixed drive enables all occur. The short run before the first frame pulse covers the unlocked state. A frame pulse placed inside channel 4 exercises the realignment corner. A final stretch with no frame pulses covers free-running wrap.

// File: rtl/iomlc_pkg.sv
`timescale 1ns/1ps
// Shared constants and the channel field layout for the line-card framer.
// Assumes the 32-bit channel format; the field order is the wire order, MSB first.
package iomlc_pkg;
    localparam int CH_BITS    = 32;
    localparam int BIT_W      = 5;   // log2(CH_BITS)
    localparam int SLOT_CYC_W = 6;   // log2(CH_BITS * 2)

    typedef struct packed {
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] mon;
        logic [1:0] d;
        logic [3:0] ci;
        logic       mr;
        logic       mx;
    } iom_chan_t;
endpackage

// File: rtl/iomlc_timing.sv
`timescale 1ns/1ps
// Frame position counter on the double-rate clock.
// Counts half-bit cycles, realigns to zero on a sampled frame pulse, and wraps
// by itself after NCH*64 cycles. Assumes fsc is synchronous to clk.
module iomlc_timing #(
    parameter int NCH = 8,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fsc,
    output logic           locked,
    output logic [CHW-1:0] ch_idx,
    output logic [4:0]     bit_idx,
    output logic           half,
    output logic           slot_last,
    output logic           load,
    output logic [CHW-1:0] next_ch,
    output logic           next_live
);
    localparam int POSW = CHW + iomlc_pkg::SLOT_CYC_W;
    localparam int LAST = NCH * iomlc_pkg::CH_BITS * 2 - 1;

    logic [POSW-1:0] pos_q;
    logic            locked_q;
    logic            frame_last;

    // Advance the half-bit position; restart on frame pulse or after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            locked_q <= 1'b0;
        end else if (fsc) begin
            pos_q    <= '0;
            locked_q <= 1'b1;
        end else if (pos_q == POSW'(LAST)) begin
            pos_q    <= '0;
        end else begin
            pos_q    <= pos_q + 1'b1;
        end
    end

    // Decode the position into channel, bit, half and slot-boundary strobes.
    always_comb begin
        ch_idx     = pos_q[POSW-1:iomlc_pkg::SLOT_CYC_W];
        bit_idx    = pos_q[iomlc_pkg::SLOT_CYC_W-1:1];
        half       = pos_q[0];
        slot_last  = half && (&bit_idx);
        frame_last = slot_last && (ch_idx == CHW'(NCH - 1));
        load       = fsc || slot_last;
        next_live  = locked_q || fsc;
        if (fsc || frame_last) next_ch = '0;
        else                   next_ch = ch_idx + 1'b1;
    end

    assign locked = locked_q;

    // R3
    fsc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsc |=> (pos_q == '0) && locked_q);

    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsc && frame_last) |=> (pos_q == '0));
endmodule

// File: rtl/iomlc_rx.sv
`timescale 1ns/1ps
// Downstream deserialiser: shifts dd once per bit and captures each channel's
// 32-bit word at the end of its slot. Assumes timing strobes come from iomlc_timing.
module iomlc_rx #(
    parameter int NCH = 8,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dd,
    input  logic                  sample,
    input  logic                  slot_last,
    input  logic [CHW-1:0]        ch_idx,
    output logic [NCH*32-1:0]     rx_words,
    output logic                  frame_end
);
    logic [30:0] sh_q;
    logic        fe_q;

    // Shift one received bit in per bit period, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)      sh_q <= '0;
        else if (sample) sh_q <= {sh_q[29:0], dd};
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [31:0] word_q;

        // Capture the full channel word when this channel's slot ends.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (sample && slot_last && (ch_idx == CHW'(c)))
                word_q <= {sh_q, dd};
        end

        assign rx_words[c*32 +: 32] = word_q;
    end

    // Strobe once the last channel of the frame has been captured.
    always_ff @(posedge clk) begin
        if (!rst_n) fe_q <= 1'b0;
        else        fe_q <= sample && slot_last && (ch_idx == CHW'(NCH - 1));
    end

    assign frame_end = fe_q;

    // R8
    frame_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_q |=> !fe_q);
endmodule

// File: rtl/iomlc_tx.sv
`timescale 1ns/1ps
// Upstream serialiser: loads a channel word and its enable at each slot start,
// then shifts one bit out per bit period. Assumes load/next_ch from iomlc_timing.
module iomlc_tx #(
    parameter int NCH = 8,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH*32-1:0]  tx_words,
    input  logic [NCH-1:0]     tx_en,
    input  logic               load,
    input  logic [CHW-1:0]     next_ch,
    input  logic               next_live,
    input  logic               half,
    output logic               du,
    output logic               du_oe
);
    logic [31:0] sh_q;
    logic        oe_q;

    // Load the next channel word at a slot start, otherwise shift after each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            oe_q <= 1'b0;
        end else if (load) begin
            sh_q <= tx_words[{next_ch, 5'd0} +: 32];
            oe_q <= tx_en[next_ch] && next_live;
        end else if (half) begin
            sh_q <= {sh_q[30:0], 1'b0};
        end
    end

    assign du    = sh_q[31] && oe_q;
    assign du_oe = oe_q;
endmodule

// File: rtl/iomlc_framer.sv
`timescale 1ns/1ps
// Line-card IOM-2 channel framer top: ties the position counter, downstream
// deserialiser and upstream serialiser together and splits received words
// into per-channel fields. Assumes clk is the double-rate data clock.
module iomlc_framer #(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsc,
    input  logic              dd,
    input  logic [NCH*32-1:0] tx_word,
    input  logic [NCH-1:0]    tx_en,
    output logic              du,
    output logic              du_oe,
    output logic [NCH*8-1:0]  rx_b1,
    output logic [NCH*8-1:0]  rx_b2,
    output logic [NCH*8-1:0]  rx_mon,
    output logic [NCH*2-1:0]  rx_d,
    output logic [NCH*4-1:0]  rx_ci,
    output logic [NCH-1:0]    rx_mr,
    output logic [NCH-1:0]    rx_mx,
    output logic              frame_end
);
    import iomlc_pkg::*;

    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic           locked, half, slot_last, load, next_live;
    logic [CHW-1:0] ch_idx, next_ch;
    logic [4:0]     bit_idx;
    logic [NCH*32-1:0] rx_words;

    iomlc_timing #(.NCH(NCH), .CHW(CHW)) u_timing (
        .clk(clk), .rst_n(rst_n), .fsc(fsc),
        .locked(locked), .ch_idx(ch_idx), .bit_idx(bit_idx), .half(half),
        .slot_last(slot_last), .load(load), .next_ch(next_ch), .next_live(next_live)
    );

    iomlc_rx #(.NCH(NCH), .CHW(CHW)) u_rx (
        .clk(clk), .rst_n(rst_n), .dd(dd), .sample(locked && half),
        .slot_last(slot_last), .ch_idx(ch_idx),
        .rx_words(rx_words), .frame_end(frame_end)
    );

    iomlc_tx #(.NCH(NCH), .CHW(CHW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_words(tx_word), .tx_en(tx_en),
        .load(load), .next_ch(next_ch), .next_live(next_live), .half(half),
        .du(du), .du_oe(du_oe)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_split
        iom_chan_t w;
        // Map one captured word onto its field outputs.
        assign w               = rx_words[c*32 +: 32];
        assign rx_b1[c*8 +: 8]  = w.b1;
        assign rx_b2[c*8 +: 8]  = w.b2;
        assign rx_mon[c*8 +: 8] = w.mon;
        assign rx_d[c*2 +: 2]   = w.d;
        assign rx_ci[c*4 +: 4]  = w.ci;
        assign rx_mr[c]         = w.mr;
        assign rx_mx[c]         = w.mx;
    end

    // R2
    unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (!du_oe && !frame_end));

    // R5
    oe_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (du_oe != $past(du_oe)) |-> (bit_idx == 5'd0 && !half));

    // R8
    frame_end_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (ch_idx == '0 && bit_idx == 5'd0 && !half && locked));
endmodule

// File: tb/iomlc_framer_bench.sv
`timescale 1ns/1ps
// Bench: behavioural frame model compared every cycle, plus directed checks.
module iomlc_framer_bench;
    localparam int NCH   = 8;
    localparam int FRAME = NCH * 64;

    logic clk = 1'b0, rst_n = 1'b0, fsc = 1'b0, dd = 1'b0;
    logic [NCH*32-1:0] tx_word;
    logic [NCH-1:0]    tx_en;
    logic du, du_oe, frame_end;
    logic [NCH*8-1:0] rx_b1, rx_b2, rx_mon;
    logic [NCH*2-1:0] rx_d;
    logic [NCH*4-1:0] rx_ci;
    logic [NCH-1:0]   rx_mr, rx_mx;

    iomlc_framer #(.NCH(NCH)) u_iomlc_framer (
        .clk(clk), .rst_n(rst_n), .fsc(fsc), .dd(dd), .tx_word(tx_word), .tx_en(tx_en),
        .du(du), .du_oe(du_oe), .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon(rx_mon),
        .rx_d(rx_d), .rx_ci(rx_ci), .rx_mr(rx_mr), .rx_mx(rx_mx), .frame_end(frame_end)
    );

    always #5 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int m_pos; bit m_locked; bit m_oe; bit m_fe;
    logic [31:0] m_sh, m_txw, cap1;
    logic [31:0] m_rx [NCH];
    logic [31:0] dd_words [NCH];
    int fe_cnt; int oe_cnt [NCH];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rx_word_of(input int c);
        return {rx_b1[c*8 +: 8], rx_b2[c*8 +: 8], rx_mon[c*8 +: 8],
                rx_d[c*2 +: 2], rx_ci[c*4 +: 4], rx_mr[c], rx_mx[c]};
    endfunction

    // Reference model: advances on each edge, compares outputs 2 ns later.
    always @(posedge clk) begin
        int c, b, nc; bit odd, fe_n;
        if (!rst_n) begin
            m_pos = 0; m_locked = 0; m_sh = '0; m_txw = '0; m_oe = 0; m_fe = 0;
            for (int i = 0; i < NCH; i++) m_rx[i] = '0;
        end else begin
            c = m_pos / 64; b = (m_pos / 2) % 32; odd = (m_pos % 2) == 1; fe_n = 0;
            if (m_locked && odd) begin
                m_sh = {m_sh[30:0], dd};
                if (b == 31) begin
                    m_rx[c] = m_sh;
                    if (c == NCH - 1) fe_n = 1;
                end
            end
            if (fsc || (odd && b == 31)) begin
                nc = fsc ? 0 : ((c == NCH - 1) ? 0 : c + 1);
                m_txw = tx_word[nc*32 +: 32];
                m_oe  = tx_en[nc] && (m_locked || fsc);
            end else if (odd) begin
                m_txw = m_txw << 1;
            end
            m_fe = fe_n;
            if (fsc) begin m_pos = 0; m_locked = 1; end
            else m_pos = (m_pos + 1) % FRAME;
        end
        #2;
        check(du_oe === m_oe, m_locked ? "R5: du_oe per slot" : "R2: du_oe before lock", 32'(du_oe), 32'(m_oe));
        if (m_oe) check(du === m_txw[31], "R4: du bit order", 32'(du), 32'(m_txw[31]));
        check(frame_end === m_fe, "R8: frame_end strobe", 32'(frame_end), 32'(m_fe));
        for (int i = 0; i < NCH; i++)
            if (rx_word_of(i) !== m_rx[i]) check(0, "R6: channel capture", rx_word_of(i), m_rx[i]);
        if (du_oe) oe_cnt[m_pos / 64]++;
        if (frame_end) fe_cnt++;
        if (m_pos / 64 == 1 && m_pos % 2 == 0) cap1[31 - (m_pos / 2) % 32] = du;
    end

    task automatic run(input int n, input bit with_fsc);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fsc = with_fsc && (i == 0);
            dd  = dd_words[m_pos / 64][31 - (m_pos / 2) % 32];
        end
    endtask

    task automatic clear_counts();
        fe_cnt = 0;
        for (int i = 0; i < NCH; i++) oe_cnt[i] = 0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        logic [7:0] old_b1;
        int tot;
        for (int c = 0; c < NCH; c++) begin
            dd_words[c] = {8'(c*17 + 3), 8'(~(c*29)), 8'(c*5 + 64), 8'(c*37 + 1)};
            tx_word[c*32 +: 32] = {8'(16 + c), 8'(8'h80 ^ 8'(c*11)), 8'(c*3 + 7), 8'(8'hF0 | 8'(c))};
        end
        tx_en = 8'b1011_0110;
        clear_counts();
        repeat (3) @(negedge clk);
        // R1: reset values
        check(du_oe == 1'b0, "R1: du_oe in reset", 32'(du_oe), 0);
        check(frame_end == 1'b0, "R1: frame_end in reset", 32'(frame_end), 0);
        check(rx_b1 == '0 && rx_ci == '0, "R1: fields in reset", rx_b1[31:0], 0);
        rst_n = 1'b1;

        // R2: no frame pulse yet, every enable set
        tx_en = '1;
        clear_counts();
        run(60, 0);
        tot = 0;
        for (int c = 0; c < NCH; c++) tot += oe_cnt[c];
        check(tot == 0, "R2: no drive before lock", 32'(tot), 0);
        check(fe_cnt == 0, "R2: no strobe before lock", 32'(fe_cnt), 0);
        check(rx_b1 == '0, "R2: fields untouched before lock", rx_b1[31:0], 0);

        // R3/R4/R5/R8: aligned frames with mixed enables
        tx_en = 8'b1011_0110;
        run(FRAME, 1);
        clear_counts();
        run(FRAME, 1);
        for (int c = 0; c < NCH; c++)
            check(oe_cnt[c] == (tx_en[c] ? 64 : 0), "R5: drive cycles per slot", 32'(oe_cnt[c]), tx_en[c] ? 64 : 0);
        check(fe_cnt == 1, "R8: one strobe per frame", 32'(fe_cnt), 1);
        check(cap1 == tx_word[63:32], "R4: channel 1 serialised MSB first (R3 slot position)", cap1, tx_word[63:32]);

        // R6/R7: field split after full frame
        run(40, 1);
        check(rx_b1[3*8 +: 8] == dd_words[3][31:24], "R7: ch3 B1", 32'(rx_b1[3*8 +: 8]), 32'(dd_words[3][31:24]));
        check(rx_mon[3*8 +: 8] == dd_words[3][15:8], "R7: ch3 Monitor", 32'(rx_mon[3*8 +: 8]), 32'(dd_words[3][15:8]));
        check(rx_ci[5*4 +: 4] == dd_words[5][5:2], "R7: ch5 C/I", 32'(rx_ci[5*4 +: 4]), 32'(dd_words[5][5:2]));
        check(rx_d[5*2 +: 2] == dd_words[5][7:6], "R7: ch5 D", 32'(rx_d[5*2 +: 2]), 32'(dd_words[5][7:6]));
        check({rx_mr[7], rx_mx[7]} == dd_words[7][1:0], "R7: ch7 MR/MX", 32'({rx_mr[7], rx_mx[7]}), 32'(dd_words[7][1:0]));
        check(rx_word_of(0) == dd_words[0], "R6: ch0 word", rx_word_of(0), dd_words[0]);

        // R6: new data and inverted enables
        for (int c = 0; c < NCH; c++) dd_words[c] = ~dd_words[c] ^ 32'(c << 9);
        tx_en = ~tx_en;
        run(FRAME, 1);
        run(FRAME, 1);
        run(40, 1);
        check(rx_word_of(2) == dd_words[2], "R6: ch2 word after update", rx_word_of(2), dd_words[2]);
        check(rx_word_of(7) == dd_words[7], "R6: ch7 word after update", rx_word_of(7), dd_words[7]);

        // R9: frame pulse inside channel 4's slot
        old_b1 = rx_b1[4*8 +: 8];
        dd_words[4] = 32'h5AC3_E718;
        run(300, 1);
        run(40, 1);
        check(rx_b1[4*8 +: 8] == old_b1, "R9: cut slot keeps old field", 32'(rx_b1[4*8 +: 8]), 32'(old_b1));
        run(FRAME, 1);
        run(40, 1);
        check(rx_word_of(4) == dd_words[4], "R9: realigned capture", rx_word_of(4), dd_words[4]);

        // R10: free running without frame pulses
        dd_words[6] = 32'h0F1E_2D3C;
        clear_counts();
        run(2 * FRAME, 0);
        check(fe_cnt == 2, "R10: strobes while free running", 32'(fe_cnt), 2);
        check(rx_word_of(6) == dd_words[6], "R10: capture while free running", rx_word_of(6), dd_words[6]);

        summary();
    end

    initial begin
        #(150000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule